// File: doc/BRIEF.md
# Per-Core Local Tick Timer Array

This block gives each processor core a private tick timer. Each timer is built from two counters in series. A prescaler divides the block clock by a programmable value plus one. A 31-bit interrupt counter then counts the prescaler's terminal ticks and raises a per-core interrupt when its count runs out. The timer either fires once and stops, or reloads its count and keeps firing until software halts it.

Software reaches every channel over one simple register port. Writes are single-cycle strobes, and reads are combinational from the address. Channel `n` has a 256-byte window whose base is byte address `0x300 + 0x100*n`. Inside the window, software programs:

- the prescaler divisor;
- the interrupt count, which must be committed with a flag bit;
- control bits;
- an interrupt enable;
- a write-one-to-clear interrupt status;
- write-acknowledge bits, which record that a register write has landed.

The number of cores and the prescaler width are parameters.

Top module: `lcl_tick_array`

## Requirements
- R1: After a synchronous active-low reset, every register of every channel reads 0 and all interrupt outputs are 0.
- R2: Address bits above the low 8 select the channel: page `3+n` is channel `n`. Inside a window, the offsets are:
  - 0x00: divisor
  - 0x08: interrupt count
  - 0x20: control
  - 0x30: status
  - 0x34: enable
  - 0x40: write-acknowledge

  Reads of any other page return 0, and writes to any other page change no channel.
- R3: While running, the prescaler produces one terminal tick every divisor+1 clock cycles.
- R4: A write to offset 0x08 with bit 31 set stores bits 30:0 as the count buffer and loads them into the interrupt counter at once. A write with bit 31 clear changes nothing. Reads of 0x08 return the buffer with bit 31 as 0.
- R5: Let N be the committed count. On the Nth terminal tick after start, status bit 0 is set. If control bit 2 is 0 (one-shot mode), control bit 1 is then cleared and no further interrupt follows.
- R6: If control bit 2 is 1 (interval mode), the counter reloads from the buffer on expiry and sets status bit 0 again every N terminal ticks.
- R7: Both counters advance only while control bit 0 and control bit 1 are both 1. Clearing either bit freezes both counters, and setting the bits again resumes the count where it stopped.
- R8: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R9: The interrupt output of a channel equals status bit 0 AND enable bit 0.
- R10: Write-acknowledge bits are set by any write to the matching register:
  - bit 0: offset 0x00
  - bit 1: offset 0x08
  - bit 3: offset 0x20

  Writing 1 to any of these bits clears it.
- R11: Channels are independent. Activity on one channel never changes another channel's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | NUM_CORES | Per-channel interrupt request |

## Verification
The bench builds the block with two cores and an 8-bit prescaler, keeping the default address width. With two cores, the page just above the last channel (0x500) is a real out-of-range address, so the decode boundary can be exercised. Two channels also make it possible to run one channel in interval mode while the other sits idle, to show that they do not disturb each other. The narrow prescaler keeps divide-by-one and divide-by-three runs short enough to check interrupt timing to the exact clock edge, including a freeze in the middle of a count followed by a resume.

// File: rtl/ltt_pkg.sv
// Package: shared register offsets, bit positions and types for the
// per-core local tick timer. Assumes 32-bit register data.
package ltt_pkg;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 31;
    localparam int BASE_PAGE = 3;

    localparam logic [7:0] OFF_DIV  = 8'h00;
    localparam logic [7:0] OFF_CNT  = 8'h08;
    localparam logic [7:0] OFF_CTRL = 8'h20;
    localparam logic [7:0] OFF_STAT = 8'h30;
    localparam logic [7:0] OFF_ENA  = 8'h34;
    localparam logic [7:0] OFF_ACK  = 8'h40;

    localparam int COMMIT_BIT  = 31;
    localparam int ACK_DIV_BIT = 0;
    localparam int ACK_CNT_BIT = 1;
    localparam int ACK_CTL_BIT = 3;

    // Control register layout, bit 2 down to bit 0.
    typedef struct packed {
        logic periodic;
        logic irq_run;
        logic tmr_run;
    } ctrl_t;
endpackage

// File: rtl/ltt_prescaler.sv
// Module: first counter stage. Counts clock cycles while enabled and emits a
// one-cycle terminal tick once the count reaches the divisor, giving one tick
// every divisor+1 enabled cycles. Assumes the divisor is held stable by
// software while running; a divisor lowered below the count ends the period.
module ltt_prescaler #(
    parameter int PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;

    assign tick = en && (pcnt >= limit);

    // Advance the divider count, wrapping on a terminal tick, hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= '0;
        else if (en)   pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/ltt_intcnt.sv
// Module: second counter stage. A down-counter of prescaler ticks that flags
// expiry on the tick that takes it through one; it then reloads from the
// buffer in periodic mode or parks at zero. A load request overrides all.
module ltt_intcnt #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    assign expire = en && tick && (cnt <= CNT_W'(1));

    // Load, reload on expiry, or step down once per prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (expire)     cnt <= periodic ? reload_val : '0;
        else if (en && tick) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/ltt_channel.sv
// Module: one core's timer channel, holding its register window, the two
// counter stages and the interrupt output. Assumes the caller raises sel only
// when the address page belongs to this channel; offs is the in-window byte.
module ltt_channel
    import ltt_pkg::*;
#(
    parameter int PRE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [7:0]        offs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [PRE_W-1:0] div_q;
    logic [CNT_W-1:0] cntbuf_q;
    ctrl_t            ctrl_q;
    logic             stat_q;
    logic             ena_q;
    logic             ack_div_q, ack_cnt_q, ack_ctl_q;

    logic wr_div, wr_cnt, wr_ctl, wr_stat, wr_ena, wr_ack;
    logic commit, run, tick, expire;

    assign wr_div  = sel && wr_en && (offs == OFF_DIV);
    assign wr_cnt  = sel && wr_en && (offs == OFF_CNT);
    assign wr_ctl  = sel && wr_en && (offs == OFF_CTRL);
    assign wr_stat = sel && wr_en && (offs == OFF_STAT);
    assign wr_ena  = sel && wr_en && (offs == OFF_ENA);
    assign wr_ack  = sel && wr_en && (offs == OFF_ACK);
    assign commit  = wr_cnt && wdata[COMMIT_BIT];
    assign run     = ctrl_q.tmr_run && ctrl_q.irq_run;

    ltt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .limit (div_q),
        .tick  (tick)
    );

    ltt_intcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (run),
        .tick       (tick),
        .load       (commit),
        .load_val   (wdata[CNT_W-1:0]),
        .reload_val (cntbuf_q),
        .periodic   (ctrl_q.periodic),
        .expire     (expire)
    );

    // Divisor and committed count buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            cntbuf_q <= '0;
        end else begin
            if (wr_div) div_q    <= wdata[PRE_W-1:0];
            if (commit) cntbuf_q <= wdata[CNT_W-1:0];
        end
    end

    // Control bits; a one-shot expiry drops the interrupt-run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctrl_q <= '0;
        else if (wr_ctl)                    ctrl_q <= ctrl_t'(wdata[2:0]);
        else if (expire && !ctrl_q.periodic) ctrl_q.irq_run <= 1'b0;
    end

    // Sticky status with write-one-to-clear; a new expiry wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                    stat_q <= 1'b0;
        else if (expire)               stat_q <= 1'b1;
        else if (wr_stat && wdata[0])  stat_q <= 1'b0;
    end

    // Interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      ena_q <= 1'b0;
        else if (wr_ena) ena_q <= wdata[0];
    end

    // Write-acknowledge bits: set by a landed write, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_div_q <= 1'b0;
            ack_cnt_q <= 1'b0;
            ack_ctl_q <= 1'b0;
        end else begin
            if (wr_div)                           ack_div_q <= 1'b1;
            else if (wr_ack && wdata[ACK_DIV_BIT]) ack_div_q <= 1'b0;
            if (wr_cnt)                           ack_cnt_q <= 1'b1;
            else if (wr_ack && wdata[ACK_CNT_BIT]) ack_cnt_q <= 1'b0;
            if (wr_ctl)                           ack_ctl_q <= 1'b1;
            else if (wr_ack && wdata[ACK_CTL_BIT]) ack_ctl_q <= 1'b0;
        end
    end

    // Read mux, gated by channel select.
    always_comb begin
        rdata = '0;
        if (sel) begin
            unique case (offs)
                OFF_DIV:  rdata = DATA_W'(div_q);
                OFF_CNT:  rdata = DATA_W'(cntbuf_q);
                OFF_CTRL: rdata = DATA_W'(ctrl_q);
                OFF_STAT: rdata = DATA_W'(stat_q);
                OFF_ENA:  rdata = DATA_W'(ena_q);
                OFF_ACK: begin
                    rdata[ACK_DIV_BIT] = ack_div_q;
                    rdata[ACK_CNT_BIT] = ack_cnt_q;
                    rdata[ACK_CTL_BIT] = ack_ctl_q;
                end
                default:  rdata = '0;
            endcase
        end
    end

    assign irq = stat_q && ena_q;
endmodule

// File: rtl/lcl_tick_array.sv
// Module: top of the per-core tick timer array. Decodes the address page into
// a channel select, instances one channel per core and ORs the gated read
// data. Assumes ADDR_W is wide enough to hold page BASE_PAGE+NUM_CORES-1.
module lcl_tick_array
    import ltt_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 12,
    parameter int PRE_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_CORES-1:0] irq_o
);
    localparam int PAGE_W = ADDR_W - 8;

    logic [PAGE_W-1:0] page;
    logic [DATA_W-1:0] ch_rd [NUM_CORES];

    assign page = addr[ADDR_W-1:8];

    for (genvar n = 0; n < NUM_CORES; n++) begin : g_ch
        logic sel;
        assign sel = (page == PAGE_W'(BASE_PAGE + n));

        ltt_channel #(.PRE_W(PRE_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel),
            .wr_en (wr_en),
            .offs  (addr[7:0]),
            .wdata (wdata),
            .rdata (ch_rd[n]),
            .irq   (irq_o[n])
        );
    end

    // Merge channel read data; at most one channel is selected.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CORES; i++) rdata = rdata | ch_rd[i];
    end
endmodule

// File: rtl/lcl_tick_array_chk.sv
// Module: assertion checker for the tick timer array, bound to the top.
// Assumes the same parameters as the bound instance.
module lcl_tick_array_chk
    import ltt_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    rdata,
    input logic [NUM_CORES-1:0] irq_o
);
    logic out_of_range;
    assign out_of_range = (int'(addr[ADDR_W-1:8]) < BASE_PAGE) ||
                          (int'(addr[ADDR_W-1:8]) >= BASE_PAGE + NUM_CORES);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> irq_o == '0);

    assert_unmapped_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> rdata == '0);

    for (genvar n = 0; n < NUM_CORES; n++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'((BASE_PAGE + n) * 256 + int'(OFF_CTRL));
        localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'((BASE_PAGE + n) * 256 + int'(OFF_ACK));

        // R9: an interrupt only drops after a register write (status clear or enable).
        assert_irq_drop_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_o[n]) |-> $past(wr_en));

        assert_ctrl_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == A_CTL) |=> (addr != A_ACK || rdata[ACK_CTL_BIT]));
    end
endmodule

bind lcl_tick_array lcl_tick_array_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .rdata (rdata),
    .irq_o (irq_o)
);

// File: tb/tb_lcl_tick_array.sv
`timescale 1ns/1ps
module tb_lcl_tick_array;
    localparam int NC = 2;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NC-1:0] irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lcl_tick_array #(.NUM_CORES(NC), .ADDR_W(AW), .PRE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        foreach (dut.irq_o[i]) ;
        rd(12'h300, v); chk("R1 div", v, 0);
        rd(12'h320, v); chk("R1 ctrl", v, 0);
        rd(12'h340, v); chk("R1 ack", v, 0);
        rd(12'h408, v); chk("R1 cnt ch1", v, 0);
        chk("R1 irq", 32'(irq_o), 0);
    endtask

    task automatic t_ack_and_commit();
        logic [31:0] v;
        wr(12'h300, 32'd2);
        rd(12'h340, v); chk("R10 div ack", v, 32'h1);
        wr(12'h308, 32'h0000_0099);
        rd(12'h340, v); chk("R10 cnt ack", v, 32'h3);
        rd(12'h308, v); chk("R4 uncommitted ignored", v, 0);
        wr(12'h320, 32'h0);
        rd(12'h340, v); chk("R10 ctrl ack", v, 32'hB);
        wr(12'h340, 32'h2);
        rd(12'h340, v); chk("R10 partial clear", v, 32'h9);
        wr(12'h340, 32'h9);
        rd(12'h340, v); chk("R10 full clear", v, 32'h0);
        wr(12'h308, 32'h8000_0015);
        rd(12'h308, v); chk("R4 commit", v, 32'h15);
        wr(12'h308, 32'h0000_0099);
        rd(12'h308, v); chk("R4 no commit bit", v, 32'h15);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        wr(12'h200, 32'hFF);
        wr(12'h500, 32'hFF);
        wr(12'h400, 32'd7);
        rd(12'h200, v); chk("R2 below window", v, 0);
        rd(12'h500, v); chk("R2 beyond last channel", v, 0);
        rd(12'h400, v); chk("R2 ch1 div", v, 7);
        rd(12'h300, v); chk("R2 ch0 div untouched", v, 2);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        // divisor 2, count 3: expiry 9 edges after start
        wr(12'h308, 32'h8000_0003);
        wr(12'h334, 32'h1);
        wr(12'h320, 32'h3);
        repeat (8) @(negedge clk);
        chk("R3 R5 no early irq", 32'(irq_o[0]), 0);
        @(negedge clk);
        chk("R3 R5 irq on 9th edge", 32'(irq_o[0]), 1);
        rd(12'h320, v); chk("R5 oneshot clears bit1", v, 32'h1);
        wr(12'h330, 32'h0);
        rd(12'h330, v); chk("R8 write 0 keeps status", v, 1);
        wr(12'h330, 32'h1);
        rd(12'h330, v); chk("R8 write 1 clears", v, 0);
        repeat (30) @(negedge clk);
        chk("R5 no second oneshot irq", 32'(irq_o[0]), 0);
    endtask

    task automatic t_enable_gate();
        logic [31:0] v;
        wr(12'h334, 32'h0);
        wr(12'h308, 32'h8000_0001);
        wr(12'h320, 32'h3);
        repeat (5) @(negedge clk);
        chk("R9 masked irq", 32'(irq_o[0]), 0);
        rd(12'h330, v); chk("R9 status set while masked", v, 1);
        wr(12'h334, 32'h1);
        chk("R9 irq after enable", 32'(irq_o[0]), 1);
        wr(12'h330, 32'h1);
        chk("R9 irq after clear", 32'(irq_o[0]), 0);
    endtask

    task automatic t_interval();
        wr(12'h400, 32'd0);
        wr(12'h408, 32'h8000_0004);
        wr(12'h434, 32'h1);
        wr(12'h420, 32'h7);
        repeat (3) @(negedge clk);
        chk("R6 no early irq", 32'(irq_o[1]), 0);
        @(negedge clk);
        chk("R6 first fire", 32'(irq_o[1]), 1);
        wr(12'h430, 32'h1);
        @(negedge clk);
        chk("R6 cleared between fires", 32'(irq_o[1]), 0);
        @(negedge clk);
        chk("R6 second fire", 32'(irq_o[1]), 1);
        chk("R11 ch0 untouched", 32'(irq_o[0]), 0);
    endtask

    task automatic t_freeze();
        wr(12'h420, 32'h0);
        wr(12'h430, 32'h1);
        wr(12'h408, 32'h8000_0006);
        wr(12'h420, 32'h7);
        wr(12'h420, 32'h5);
        repeat (10) @(negedge clk);
        chk("R7 frozen no irq", 32'(irq_o[1]), 0);
        wr(12'h420, 32'h7);
        repeat (3) @(negedge clk);
        chk("R7 resume not early", 32'(irq_o[1]), 0);
        @(negedge clk);
        chk("R7 resume fires on remaining count", 32'(irq_o[1]), 1);
        wr(12'h420, 32'h0);
        wr(12'h430, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ack_and_commit();
        t_decode();
        t_oneshot();
        t_enable_gate();
        t_interval();
        t_freeze();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule